// File: doc/BRIEF.md
# Per-Thread Fetch Address and Miss Controller

This block holds the next instruction fetch address for each hardware thread and drives the instruction cache miss path toward the L2. Every cycle, each thread's address is updated in one of three ways. A redirect loads it with the redirect target. A granted fetch moves it to the start of the following 16-byte group. Otherwise it holds its value. The fetch arbiter reads `fetch_en` to see which threads may fetch, and reports its pick on `grant_vld`/`grant_tid`.

When the cache lookup reports a miss, the thread's address is wound back to the missing address and the thread is blocked. A line request then goes out on a valid/ready stream to the L2. A thread may have only one line outstanding. A thread that a redirect has re-enabled and that misses again keeps its new miss in a one-entry holding register. That request goes out in the cycle after the first line is accepted.

Returning lines arrive on a valid/ready fill stream. A line is written into the cache only if it falls in the same 2 KB region as the thread's current fetch address; otherwise it is dropped. A written line occupies the single-ported data array. That stops all fetching for four cycles and holds `fill_ready` low. A back-invalidation stops all fetching for one cycle.

Top module: `fetch_miss_ctl`

## Requirements
- R1: After reset, every fetch address is 0 and every thread is enabled. `req_valid` is 0, `fill_ready` is 1 and `fetch_stall` is 0.
- R2: When `flush_vld[t]` is high, thread t's fetch address in the next cycle is `flush_tgt[t]`. This overrides a miss or a grant in the same cycle.
- R3: A grant to an enabled thread changes its address to (address with bits 3:0 cleared) + 16. Threads that are not granted keep their address. A grant to a thread whose `fetch_en` is 0 is ignored.
- R4: A miss on thread t sets its address to `miss_addr` and clears `fetch_en[t]` in the next cycle.
- R5: The request stream carries `req_addr` with bits 5:0 cleared. If `req_valid` is high and `req_ready` is low, then `req_valid`, `req_tid` and `req_addr` hold in the next cycle. A request leaves the stream once a cycle has both valid and ready high.
- R6: A redirect re-enables a thread that is blocked on a miss while its line is still outstanding. A redirect also drops any held second miss for that thread.
- R7: A miss on a thread that already has a line outstanding sends no request and leaves the thread blocked. Its request appears on the stream in the cycle after the first line is accepted. The thread then stays blocked until that second line is accepted.
- R8: When a line is accepted for a thread that has no held second miss, that thread is re-enabled in the next cycle, unless a stall is active.
- R9: An accepted line is written (`fill_wr` high in the accepting cycle) only when `fill_addr` and the thread's current address agree in bits 31:11. Otherwise it is dropped, and `fill_wr` stays low.
- R10: A written line raises `fetch_stall` and lowers `fill_ready` for the four cycles after acceptance. A dropped line raises neither.
- R11: A back-invalidation pulse raises `fetch_stall` for the one following cycle.
- R12: While `fetch_stall` is high, every `fetch_en` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_vld | input | 4 | Per-thread redirect strobe |
| flush_tgt | input | 4x32 | Per-thread redirect target |
| grant_vld | input | 1 | A thread was picked for fetch this cycle |
| grant_tid | input | 2 | Picked thread |
| miss_vld | input | 1 | Cache lookup missed |
| miss_tid | input | 2 | Thread that missed |
| miss_addr | input | 32 | Fetch address that missed |
| req_valid | output | 1 | Line request is valid |
| req_ready | input | 1 | L2 takes the request |
| req_tid | output | 2 | Requesting thread |
| req_addr | output | 32 | Line address (64-byte aligned) |
| fill_valid | input | 1 | Returned line is valid |
| fill_ready | output | 1 | Data array can accept a line |
| fill_tid | input | 2 | Thread the line belongs to |
| fill_addr | input | 32 | Address of the returned line |
| fill_wr | output | 1 | Accepted line is to be written |
| binv_vld | input | 1 | Back-invalidation from L2 |
| fetch_addr | output | 4x32 | Next fetch address per thread |
| fetch_en | output | 4 | Thread may be picked for fetch |
| fetch_stall | output | 1 | Global fetch block |

## Verification
Address updates from redirect, grant and miss show one cycle after the strobe. The bench drives on the falling edge and checks at the next falling edge, after exactly one rising edge. `fill_wr` depends combinationally on the fill inputs, so it is checked in the same cycle, just after driving. The four-cycle and one-cycle stalls are checked in each of the falling edges that follow acceptance, and also in the first falling edge after the window ends. A held second-miss request is checked in the cycle right after its predecessor's line is accepted, and while `req_ready` is low the bench checks each cycle that the request holds still.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam int unsigned DEF_NTHR       = 4;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_GROUP_LG   = 4;
  localparam int unsigned DEF_LINE_LG    = 6;
  localparam int unsigned DEF_REGION_LG  = 11;
  localparam int unsigned DEF_FILL_STALL = 4;
endpackage

// File: rtl/fmc_thread.sv
module fmc_thread #(
  parameter int unsigned ADDR_W    = fmc_pkg::DEF_ADDR_W,
  parameter int unsigned GROUP_LG  = fmc_pkg::DEF_GROUP_LG,
  parameter int unsigned LINE_LG   = fmc_pkg::DEF_LINE_LG,
  parameter int unsigned REGION_LG = fmc_pkg::DEF_REGION_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_tgt_i,
  input  logic              grant_i,
  input  logic              miss_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              req_take_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              blocked_o,
  output logic              keep_o,
  output logic              req_need_o,
  output logic [ADDR_W-1:0] req_addr_o
);
  localparam logic [ADDR_W-1:0] ONE   = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] GSTEP = ONE << GROUP_LG;
  localparam logic [ADDR_W-1:0] GMASK = GSTEP - ONE;
  localparam logic [ADDR_W-1:0] LMASK = (ONE << LINE_LG) - ONE;

  logic [ADDR_W-1:0] addr_q, addr_d, pend_q, pend_d, raddr_q, raddr_d;
  logic              blk_q, blk_d, out_q, out_d, pv_q, pv_d, rn_q, rn_d;

  assign keep_o = ((fill_addr_i ^ addr_q) >> REGION_LG) == '0;

  always_comb begin
    addr_d  = addr_q;
    pend_d  = pend_q;
    raddr_d = raddr_q;
    blk_d   = blk_q;
    out_d   = out_q;
    pv_d    = pv_q;
    rn_d    = rn_q;
    if (req_take_i) rn_d = 1'b0;
    if (fill_i) begin
      if (pv_q && !flush_i) begin
        rn_d    = 1'b1;
        raddr_d = pend_q & ~LMASK;
        pv_d    = 1'b0;
      end else begin
        out_d = 1'b0;
        blk_d = 1'b0;
      end
    end
    if (flush_i) begin
      addr_d = flush_tgt_i;
      blk_d  = 1'b0;
      pv_d   = 1'b0;
    end else if (miss_i && !pv_q) begin
      addr_d = miss_addr_i;
      blk_d  = 1'b1;
      if (!out_d) begin
        rn_d    = 1'b1;
        raddr_d = miss_addr_i & ~LMASK;
        out_d   = 1'b1;
      end else begin
        pv_d   = 1'b1;
        pend_d = miss_addr_i;
      end
    end else if (grant_i) begin
      addr_d = (addr_q & ~GMASK) + GSTEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      pend_q  <= '0;
      raddr_q <= '0;
      blk_q   <= 1'b0;
      out_q   <= 1'b0;
      pv_q    <= 1'b0;
      rn_q    <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      pend_q  <= pend_d;
      raddr_q <= raddr_d;
      blk_q   <= blk_d;
      out_q   <= out_d;
      pv_q    <= pv_d;
      rn_q    <= rn_d;
    end
  end

  assign addr_o     = addr_q;
  assign blocked_o  = blk_q;
  assign req_need_o = rn_q;
  assign req_addr_o = raddr_q;
endmodule

// File: rtl/fmc_req_arb.sv
module fmc_req_arb #(
  parameter int unsigned NTHR   = fmc_pkg::DEF_NTHR,
  parameter int unsigned ADDR_W = fmc_pkg::DEF_ADDR_W,
  localparam int unsigned TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NTHR-1:0]             need_i,
  input  logic [NTHR-1:0][ADDR_W-1:0] addr_i,
  input  logic                        ready_i,
  output logic                        valid_o,
  output logic [TID_W-1:0]            tid_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [NTHR-1:0]             take_o
);
  logic             lock_q;
  logic [TID_W-1:0] lock_tid_q, pick;

  always_comb begin
    pick = '0;
    for (int i = NTHR - 1; i >= 0; i--) begin
      if (need_i[i]) pick = TID_W'(i);
    end
  end

  assign valid_o = |need_i;
  assign tid_o   = lock_q ? lock_tid_q : pick;
  assign addr_o  = addr_i[tid_o];

  always_comb begin
    take_o = '0;
    if (valid_o && ready_i) take_o[tid_o] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_tid_q <= '0;
    end else begin
      lock_q     <= valid_o && !ready_i;
      lock_tid_q <= tid_o;
    end
  end
endmodule

// File: rtl/fmc_stall.sv
module fmc_stall #(
  parameter int unsigned FILL_STALL = fmc_pkg::DEF_FILL_STALL,
  localparam int unsigned CNT_W = $clog2(FILL_STALL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_wr_i,
  input  logic binv_i,
  output logic stall_o,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             binv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      binv_q <= 1'b0;
    end else begin
      binv_q <= binv_i;
      if (fill_wr_i)        cnt_q <= CNT_W'(FILL_STALL);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = cnt_q != '0;
  assign stall_o = busy_o || binv_q;
endmodule

// File: rtl/fetch_miss_ctl.sv
module fetch_miss_ctl #(
  parameter int unsigned NTHR       = fmc_pkg::DEF_NTHR,
  parameter int unsigned ADDR_W     = fmc_pkg::DEF_ADDR_W,
  parameter int unsigned GROUP_LG   = fmc_pkg::DEF_GROUP_LG,
  parameter int unsigned LINE_LG    = fmc_pkg::DEF_LINE_LG,
  parameter int unsigned REGION_LG  = fmc_pkg::DEF_REGION_LG,
  parameter int unsigned FILL_STALL = fmc_pkg::DEF_FILL_STALL,
  localparam int unsigned TID_W     = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NTHR-1:0]             flush_vld,
  input  logic [NTHR-1:0][ADDR_W-1:0] flush_tgt,
  input  logic                        grant_vld,
  input  logic [TID_W-1:0]            grant_tid,
  input  logic                        miss_vld,
  input  logic [TID_W-1:0]            miss_tid,
  input  logic [ADDR_W-1:0]           miss_addr,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic [TID_W-1:0]            req_tid,
  output logic [ADDR_W-1:0]           req_addr,
  input  logic                        fill_valid,
  output logic                        fill_ready,
  input  logic [TID_W-1:0]            fill_tid,
  input  logic [ADDR_W-1:0]           fill_addr,
  output logic                        fill_wr,
  input  logic                        binv_vld,
  output logic [NTHR-1:0][ADDR_W-1:0] fetch_addr,
  output logic [NTHR-1:0]             fetch_en,
  output logic                        fetch_stall
);
  logic [NTHR-1:0]             blocked, keep, need, take;
  logic [NTHR-1:0][ADDR_W-1:0] raddr;
  logic                        busy, fill_acc;

  assign fill_ready = !busy;
  assign fill_acc   = fill_valid && fill_ready;
  assign fill_wr    = fill_acc && keep[fill_tid];

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    assign fetch_en[g] = !blocked[g] && !fetch_stall;

    fmc_thread #(
      .ADDR_W(ADDR_W), .GROUP_LG(GROUP_LG),
      .LINE_LG(LINE_LG), .REGION_LG(REGION_LG)
    ) u_thr (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_vld[g]),
      .flush_tgt_i(flush_tgt[g]),
      .grant_i    (grant_vld && grant_tid == TID_W'(g) && fetch_en[g]),
      .miss_i     (miss_vld && miss_tid == TID_W'(g)),
      .miss_addr_i(miss_addr),
      .fill_i     (fill_acc && fill_tid == TID_W'(g)),
      .fill_addr_i(fill_addr),
      .req_take_i (take[g]),
      .addr_o     (fetch_addr[g]),
      .blocked_o  (blocked[g]),
      .keep_o     (keep[g]),
      .req_need_o (need[g]),
      .req_addr_o (raddr[g])
    );
  end

  fmc_req_arb #(.NTHR(NTHR), .ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .need_i (need),
    .addr_i (raddr),
    .ready_i(req_ready),
    .valid_o(req_valid),
    .tid_o  (req_tid),
    .addr_o (req_addr),
    .take_o (take)
  );

  fmc_stall #(.FILL_STALL(FILL_STALL)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_wr_i(fill_wr),
    .binv_i   (binv_vld),
    .stall_o  (fetch_stall),
    .busy_o   (busy)
  );
endmodule

// File: rtl/fmc_chk.sv
module fmc_chk #(
  parameter int unsigned NTHR    = fmc_pkg::DEF_NTHR,
  parameter int unsigned ADDR_W  = fmc_pkg::DEF_ADDR_W,
  parameter int unsigned LINE_LG = fmc_pkg::DEF_LINE_LG,
  localparam int unsigned TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NTHR-1:0]             flush_vld,
  input logic [NTHR-1:0][ADDR_W-1:0] flush_tgt,
  input logic                        miss_vld,
  input logic [TID_W-1:0]            miss_tid,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [TID_W-1:0]            req_tid,
  input logic [ADDR_W-1:0]           req_addr,
  input logic                        fill_ready,
  input logic                        fill_wr,
  input logic                        binv_vld,
  input logic [NTHR-1:0][ADDR_W-1:0] fetch_addr,
  input logic [NTHR-1:0]             fetch_en,
  input logic                        fetch_stall
);
  for (genvar g = 0; g < NTHR; g++) begin : g_fl
    assert_flush_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld[g] |=> fetch_addr[g] == $past(flush_tgt[g]));
  end

  assert_miss_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld && !flush_vld[miss_tid] |=> !fetch_en[$past(miss_tid)]);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_tid) && $stable(req_addr));

  assert_req_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[LINE_LG-1:0] == '0);

  assert_write_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr |=> fetch_stall && !fill_ready);

  assert_binv_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    binv_vld |=> fetch_stall);

  assert_stall_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> fetch_en == '0);
endmodule

bind fetch_miss_ctl fmc_chk #(.NTHR(NTHR), .ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_vld(flush_vld), .flush_tgt(flush_tgt),
  .miss_vld(miss_vld), .miss_tid(miss_tid), .req_valid(req_valid),
  .req_ready(req_ready), .req_tid(req_tid), .req_addr(req_addr),
  .fill_ready(fill_ready), .fill_wr(fill_wr), .binv_vld(binv_vld),
  .fetch_addr(fetch_addr), .fetch_en(fetch_en), .fetch_stall(fetch_stall)
);

// File: tb/tb_fetch_miss_ctl.sv
module tb_fetch_miss_ctl;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        flush_vld = '0;
  logic [3:0][31:0]  flush_tgt = '0;
  logic              grant_vld = 1'b0;
  logic [1:0]        grant_tid = '0;
  logic              miss_vld = 1'b0;
  logic [1:0]        miss_tid = '0;
  logic [31:0]       miss_addr = '0;
  logic              req_valid, req_ready = 1'b0;
  logic [1:0]        req_tid;
  logic [31:0]       req_addr;
  logic              fill_valid = 1'b0, fill_ready;
  logic [1:0]        fill_tid = '0;
  logic [31:0]       fill_addr = '0;
  logic              fill_wr, binv_vld = 1'b0;
  logic [3:0][31:0]  fetch_addr;
  logic [3:0]        fetch_en;
  logic              fetch_stall;

  int   nvec = 0, nbad = 0;
  bit   done = 1'b0;
  logic [31:0] exp_addr [4];

  always #5 clk = ~clk;

  fetch_miss_ctl dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_flush(input int t, input logic [31:0] a);
    flush_vld = 4'(1 << t);
    flush_tgt[t] = a;
    tick();
    flush_vld = '0;
    exp_addr[t] = a;
  endtask

  task automatic do_miss(input int t, input logic [31:0] a);
    miss_vld = 1'b1; miss_tid = 2'(t); miss_addr = a;
    tick();
    miss_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    for (int t = 0; t < 4; t++) begin
      chk("R1 reset addr", fetch_addr[t], 32'h0);
      exp_addr[t] = '0;
    end
    chk("R1 reset en", 32'(fetch_en), 32'hF);
    chk("R1 reset req_valid", 32'(req_valid), 32'h0);
    chk("R1 reset fill_ready", 32'(fill_ready), 32'h1);
    chk("R1 reset stall", 32'(fetch_stall), 32'h0);

    // R2/R3 sweep over every thread and every offset within a group
    for (int t = 0; t < 4; t++) begin
      for (int off = 0; off < 16; off++) begin
        logic [31:0] tg;
        tg = 32'h0010_0000 + 32'(t << 12) + 32'(off);
        do_flush(t, tg);
        chk("R2 flush target", fetch_addr[t], tg);
        grant_vld = 1'b1; grant_tid = 2'(t);
        tick();
        grant_vld = 1'b0;
        exp_addr[t] = (tg & ~32'hF) + 32'h10;
        chk("R3 grant advance", fetch_addr[t], exp_addr[t]);
        chk("R3 others hold", fetch_addr[(t + 1) % 4], exp_addr[(t + 1) % 4]);
      end
    end

    // R2 flush beats a same-cycle miss
    flush_vld = 4'b0001; flush_tgt[0] = 32'h0000_7770;
    miss_vld = 1'b1; miss_tid = 2'd0; miss_addr = 32'h0000_1234;
    tick();
    flush_vld = '0; miss_vld = 1'b0;
    chk("R2 flush over miss addr", fetch_addr[0], 32'h0000_7770);
    chk("R2 flush over miss en", 32'(fetch_en[0]), 32'h1);
    chk("R2 flush over miss no req", 32'(req_valid), 32'h0);

    // R4/R5 first miss on thread 1
    do_miss(1, 32'h0000_4A24);
    chk("R4 miss rewinds", fetch_addr[1], 32'h0000_4A24);
    chk("R4 miss blocks", 32'(fetch_en[1]), 32'h0);
    chk("R5 req valid", 32'(req_valid), 32'h1);
    chk("R5 req tid", 32'(req_tid), 32'h1);
    chk("R5 req line addr", req_addr, 32'h0000_4A00);
    grant_vld = 1'b1; grant_tid = 2'd1;
    tick();
    grant_vld = 1'b0;
    chk("R3 grant to blocked ignored", fetch_addr[1], 32'h0000_4A24);
    chk("R5 held valid", 32'(req_valid), 32'h1);
    chk("R5 held addr", req_addr, 32'h0000_4A00);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    chk("R5 req gone after handshake", 32'(req_valid), 32'h0);

    // R6 redirect re-enables while line outstanding
    do_flush(1, 32'h0000_4B00);
    chk("R6 flush re-enables", 32'(fetch_en[1]), 32'h1);
    grant_vld = 1'b1; grant_tid = 2'd1;
    tick();
    grant_vld = 1'b0;
    chk("R3 grant after re-enable", fetch_addr[1], 32'h0000_4B10);

    // R7 second miss is held
    do_miss(1, 32'h0000_4C40);
    chk("R7 second miss addr", fetch_addr[1], 32'h0000_4C40);
    chk("R7 second miss blocks", 32'(fetch_en[1]), 32'h0);
    chk("R7 second miss no req", 32'(req_valid), 32'h0);
    tick();
    chk("R7 still no req", 32'(req_valid), 32'h0);

    // first line returns, same region -> written
    fill_valid = 1'b1; fill_tid = 2'd1; fill_addr = 32'h0000_4A00;
    #1;
    chk("R9 same region written", 32'(fill_wr), 32'h1);
    @(negedge clk);
    fill_valid = 1'b0;
    chk("R10 stall cycle 1", 32'(fetch_stall), 32'h1);
    chk("R10 fill_ready low", 32'(fill_ready), 32'h0);
    chk("R12 en gated", 32'(fetch_en), 32'h0);
    chk("R7 held req issued", 32'(req_valid), 32'h1);
    chk("R7 held req tid", 32'(req_tid), 32'h1);
    chk("R7 held req addr", req_addr, 32'h0000_4C40);
    req_ready = 1'b1;
    for (int k = 2; k <= 4; k++) begin
      tick();
      req_ready = 1'b0;
      chk("R10 stall window", 32'(fetch_stall), 32'h1);
      chk("R10 fill_ready window", 32'(fill_ready), 32'h0);
    end
    chk("R5 req consumed", 32'(req_valid), 32'h0);
    tick();
    chk("R10 stall ends", 32'(fetch_stall), 32'h0);
    chk("R10 fill_ready back", 32'(fill_ready), 32'h1);
    chk("R7 still blocked", 32'(fetch_en[1]), 32'h0);

    // second line returns -> thread re-enabled
    fill_valid = 1'b1; fill_tid = 2'd1; fill_addr = 32'h0000_4C40;
    #1;
    chk("R9 second fill written", 32'(fill_wr), 32'h1);
    @(negedge clk);
    fill_valid = 1'b0;
    repeat (4) tick();
    chk("R8 thread re-enabled", 32'(fetch_en[1]), 32'h1);
    chk("R8 addr kept", fetch_addr[1], 32'h0000_4C40);

    // R9/R10 dropped line on thread 2
    do_miss(2, 32'h8000_0100);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    do_flush(2, 32'h9000_0000);
    fill_valid = 1'b1; fill_tid = 2'd2; fill_addr = 32'h8000_0100;
    #1;
    chk("R9 other region dropped", 32'(fill_wr), 32'h0);
    @(negedge clk);
    fill_valid = 1'b0;
    chk("R10 no stall on drop", 32'(fetch_stall), 32'h0);
    chk("R10 ready on drop", 32'(fill_ready), 32'h1);
    chk("R8 en after drop", 32'(fetch_en[2]), 32'h1);
    chk("R9 addr untouched", fetch_addr[2], 32'h9000_0000);

    // R6 redirect drops a held second miss on thread 3
    do_miss(3, 32'h0000_2000);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    do_flush(3, 32'h0000_2100);
    do_miss(3, 32'h0000_2200);
    chk("R7 t3 blocked", 32'(fetch_en[3]), 32'h0);
    do_flush(3, 32'h0004_0000);
    chk("R6 flush unblocks held", 32'(fetch_en[3]), 32'h1);
    fill_valid = 1'b1; fill_tid = 2'd3; fill_addr = 32'h0000_2000;
    tick();
    fill_valid = 1'b0;
    chk("R6 held miss dropped", 32'(req_valid), 32'h0);
    chk("R6 t3 enabled", 32'(fetch_en[3]), 32'h1);

    // R11 back-invalidation
    binv_vld = 1'b1;
    tick();
    binv_vld = 1'b0;
    chk("R11 binv stall", 32'(fetch_stall), 32'h1);
    chk("R12 binv gates en", 32'(fetch_en), 32'h0);
    grant_vld = 1'b1; grant_tid = 2'd0;
    tick();
    grant_vld = 1'b0;
    chk("R11 binv one cycle", 32'(fetch_stall), 32'h0);
    chk("R3 grant during stall ignored", fetch_addr[0], 32'h0000_7770);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule